// File: doc/BRIEF.md
# Microcoded 16-bit Register Datapath

This block is the execution datapath of a small 16-bit processor. It makes no decisions of its own. Every cycle an external microsequencer drives a set of control lines that choose which registers are read, what is written back, which operation the function unit performs, how the program counter moves, and which latches capture a value. The datapath holds a 32-entry register file, two operand latches that feed a function unit with a 4-bit operation code, a 15-bit program counter, a data-out register, an address register and the multiplexer that drives the address output. It also reports whether the register on the first read port is zero.

The first register selector has three jobs. It names the write target, it drives read port A, and it is the source for the data-out register, the address register, the A latch and the register-sourced PC load. The second selector drives read port B, which feeds the B latch and the register-copy write source. Register reads are combinational, so a value written at one clock edge can be captured by any latch at the next edge. The PC and address paths are 15 bits wide and drop bit 15 of any 16-bit value loaded into them.

Top module: `cpu_datapath`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, every register file entry, A, B, the data-out register and the address register clear to 0 and the PC becomes 0x7FFE. After reset, `dout` reads 0x0000 and `addr` reads 0x7FFE with `addr_sel` = 0.
- R2: When `we` is high at a rising edge, the entry named by `sel_a` takes the write data. With `wsrc` = 00 the write data is `din`.
- R3: Write source `wsrc` = 01 stores the current PC, zero-extended to 16 bits. `wsrc` = 10 stores the function-unit result. `wsrc` = 11 stores the entry read through `sel_b`. Every source is sampled before that edge's updates.
- R4: While `we` is low, no register file entry changes.
- R5: With `pc_ld` high, `pc_src` = 00 loads PC+1 modulo 2^15, `pc_src` = 01 loads `din[14:0]`, and `pc_src` = 10 loads bits 14:0 of the entry named by `sel_a`. With `pc_src` = 11, or with `pc_ld` low, the PC holds.
- R6: `addr` shows the PC when `addr_sel` = 0 and the address register when `addr_sel` = 1.
- R7: `dout_ld` loads the data-out register from the entry named by `sel_a`. `ar_ld` loads the address register from bits 14:0 of the same entry. Each holds while its strobe is low.
- R8: `a_ld` loads latch A from read port A (`sel_a`), and `b_ld` loads latch B from read port B (`sel_b`).
- R9: The function unit computes from A and B, with all arithmetic modulo 2^16. The codes are 0000 A+1, 0001 A-1, 0010 A, 0011 B, 0111 A+B, 1000 A-B, 1010 A AND B, 1011 A OR B, 1100 A XOR B, 1101 NOT A, 1110 A shifted left by one, and 1111 A shifted right by one with a 0 shifted in. The unused codes 0100, 0101, 0110 and 1001 return A.
- R10: `zero` is high exactly when the entry read through `sel_a` holds 0x0000, and `nzero` is always its complement.
- R11: When a register write and a load from the same entry occur in the same cycle, the load takes the value from before the write. When the PC is written to the register file in the same cycle that it changes, the stored value is the PC from before the change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| sel_a | input | 5 | Read port A selector and write address |
| sel_b | input | 5 | Read port B selector |
| wsrc | input | 2 | Register write source select |
| op | input | 4 | Function unit operation code |
| we | input | 1 | Register file write enable |
| pc_src | input | 2 | PC load source select |
| pc_ld | input | 1 | PC load enable |
| dout_ld | input | 1 | Data-out register load strobe |
| ar_ld | input | 1 | Address register load strobe |
| a_ld | input | 1 | Operand latch A load strobe |
| b_ld | input | 1 | Operand latch B load strobe |
| addr_sel | input | 1 | Address output select: 0 PC, 1 address register |
| din | input | 16 | External data input |
| zero | output | 1 | Entry on read port A is zero |
| nzero | output | 1 | Complement of `zero` |
| dout | output | 16 | Data-out register |
| addr | output | 15 | Address output |

## Verification
Two functions can collide in one cycle. The first is a register write together with a latch load from the entry being written. The second is a PC change together with a write of the PC into the register file. The bench provokes the first by writing a fresh value to an entry while strobing `dout_ld` on that same entry. It passes when `dout` shows the old contents at once and the new contents only after a second load. It provokes the second by incrementing the PC while storing it. It passes when the stored entry equals the PC from before the increment and the address output shows the incremented value.

// File: rtl/dp_pkg.sv
`timescale 1ns/1ps
// Package dp_pkg
// Shared codes for the register datapath. These are the write-source,
// PC-source and function-unit operation encodings. The microsequencer
// drives these values, so they must not be renumbered.
package dp_pkg;

    // Register file write source
    localparam logic [1:0] WSRC_DIN  = 2'b00;
    localparam logic [1:0] WSRC_PC   = 2'b01;
    localparam logic [1:0] WSRC_ALU  = 2'b10;
    localparam logic [1:0] WSRC_REGB = 2'b11;

    // Program counter load source
    localparam logic [1:0] PCSRC_INC = 2'b00;
    localparam logic [1:0] PCSRC_DIN = 2'b01;
    localparam logic [1:0] PCSRC_REG = 2'b10;

    // Function unit operations
    typedef enum logic [3:0] {
        OP_INC   = 4'h0,
        OP_DEC   = 4'h1,
        OP_PASSA = 4'h2,
        OP_PASSB = 4'h3,
        OP_ADD   = 4'h7,
        OP_SUB   = 4'h8,
        OP_AND   = 4'hA,
        OP_OR    = 4'hB,
        OP_XOR   = 4'hC,
        OP_NOT   = 4'hD,
        OP_SHL   = 4'hE,
        OP_SHR   = 4'hF
    } alu_op_e;

endpackage

// File: rtl/dp_regfile.sv
`timescale 1ns/1ps
// Module dp_regfile
// Multi-entry register file with one write port and two combinational
// read ports. A read sees the contents from before the current edge's
// write, so a write and a read of the same entry in one cycle return
// the old value.
// Assumes: rst_n is synchronous and active low. NREG is a power of two.
module dp_regfile #(
    parameter int DW   = 16,
    parameter int NREG = 32,
    localparam int SELW = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we,
    input  logic [SELW-1:0] waddr,
    input  logic [DW-1:0]   wdata,
    input  logic [SELW-1:0] raddr_a,
    input  logic [SELW-1:0] raddr_b,
    output logic [DW-1:0]   rdata_a,
    output logic [DW-1:0]   rdata_b
);

    logic [NREG-1:0]          row_wen;
    logic [NREG-1:0][DW-1:0]  mem_q;

    // Purpose: one write-enable decode per entry
    for (genvar g = 0; g < NREG; g++) begin : g_dec
        assign row_wen[g] = we && (waddr == SELW'(g));
    end

    // Purpose: store write data into the decoded entry, clear all on reset
    always_ff @(posedge clk) begin
        for (int i = 0; i < NREG; i++) begin
            if (!rst_n) begin
                mem_q[i] <= '0;
            end else if (row_wen[i]) begin
                mem_q[i] <= wdata;
            end
        end
    end

    // Purpose: combinational read ports
    assign rdata_a = mem_q[raddr_a];
    assign rdata_b = mem_q[raddr_b];

endmodule

// File: rtl/dp_alu.sv
`timescale 1ns/1ps
// Module dp_alu
// Combinational function unit. It takes the two operand latches and a
// 4-bit operation code and gives one result. Arithmetic wraps modulo
// 2^DW. Unused codes pass operand A through.
// Assumes: op follows dp_pkg::alu_op_e.
module dp_alu
    import dp_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic [3:0]    op,
    input  logic [DW-1:0] opa,
    input  logic [DW-1:0] opb,
    output logic [DW-1:0] res
);

    // Purpose: select the result for the requested operation
    always_comb begin
        unique case (op)
            OP_INC:   res = opa + DW'(1);
            OP_DEC:   res = opa - DW'(1);
            OP_PASSA: res = opa;
            OP_PASSB: res = opb;
            OP_ADD:   res = opa + opb;
            OP_SUB:   res = opa - opb;
            OP_AND:   res = opa & opb;
            OP_OR:    res = opa | opb;
            OP_XOR:   res = opa ^ opb;
            OP_NOT:   res = ~opa;
            OP_SHL:   res = {opa[DW-2:0], 1'b0};
            OP_SHR:   res = {1'b0, opa[DW-1:1]};
            default:  res = opa;
        endcase
    end

endmodule

// File: rtl/dp_pc.sv
`timescale 1ns/1ps
// Module dp_pc
// Program counter with three load sources: increment, external data and
// a register value. It holds when load is low or when the source code
// is the unused one.
// Assumes: the callers have already cut the source values to AW bits.
module dp_pc
    import dp_pkg::*;
#(
    parameter int          AW       = 15,
    parameter logic [AW-1:0] PC_RESET = '1 - AW'(1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld,
    input  logic [1:0]    src,
    input  logic [AW-1:0] din_val,
    input  logic [AW-1:0] reg_val,
    output logic [AW-1:0] pc_q
);

    logic [AW-1:0] pc_nxt;

    // Purpose: choose the next PC value
    always_comb begin
        pc_nxt = pc_q;
        if (ld) begin
            unique case (src)
                PCSRC_INC: pc_nxt = pc_q + AW'(1);
                PCSRC_DIN: pc_nxt = din_val;
                PCSRC_REG: pc_nxt = reg_val;
                default:   pc_nxt = pc_q;
            endcase
        end
    end

    // Purpose: PC register with reset value
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q <= PC_RESET;
        end else begin
            pc_q <= pc_nxt;
        end
    end

endmodule

// File: rtl/cpu_datapath.sv
`timescale 1ns/1ps
// Module cpu_datapath
// Top of the register datapath. It holds the register file and the
// write-source mux, the operand latches A and B, the function unit, the
// PC, the data-out register, the address register, the address output
// mux and the zero flags. All control comes from an external
// microsequencer, one set of lines per cycle.
// Assumes: synchronous active-low reset; sel_a is both the write
// address and read port A.
module cpu_datapath
    import dp_pkg::*;
#(
    parameter int DW   = 16,
    parameter int AW   = 15,
    parameter int NREG = 32,
    localparam int SELW = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [SELW-1:0] sel_a,
    input  logic [SELW-1:0] sel_b,
    input  logic [1:0]      wsrc,
    input  logic [3:0]      op,
    input  logic            we,
    input  logic [1:0]      pc_src,
    input  logic            pc_ld,
    input  logic            dout_ld,
    input  logic            ar_ld,
    input  logic            a_ld,
    input  logic            b_ld,
    input  logic            addr_sel,
    input  logic [DW-1:0]   din,
    output logic            zero,
    output logic            nzero,
    output logic [DW-1:0]   dout,
    output logic [AW-1:0]   addr
);

    localparam int PADW = DW - AW;

    logic [DW-1:0] rd_a;
    logic [DW-1:0] rd_b;
    logic [DW-1:0] wr_data;
    logic [DW-1:0] opa_q;
    logic [DW-1:0] opb_q;
    logic [DW-1:0] alu_res;
    logic [DW-1:0] dout_q;
    logic [AW-1:0] ar_q;
    logic [AW-1:0] pc_q;

    dp_regfile #(.DW(DW), .NREG(NREG)) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (we),
        .waddr   (sel_a),
        .wdata   (wr_data),
        .raddr_a (sel_a),
        .raddr_b (sel_b),
        .rdata_a (rd_a),
        .rdata_b (rd_b)
    );

    dp_alu #(.DW(DW)) u_alu (
        .op  (op),
        .opa (opa_q),
        .opb (opb_q),
        .res (alu_res)
    );

    dp_pc #(.AW(AW)) u_pc (
        .clk     (clk),
        .rst_n   (rst_n),
        .ld      (pc_ld),
        .src     (pc_src),
        .din_val (din[AW-1:0]),
        .reg_val (rd_a[AW-1:0]),
        .pc_q    (pc_q)
    );

    // Purpose: choose the register file write data
    always_comb begin
        unique case (wsrc)
            WSRC_DIN:  wr_data = din;
            WSRC_PC:   wr_data = {{PADW{1'b0}}, pc_q};
            WSRC_ALU:  wr_data = alu_res;
            default:   wr_data = rd_b;
        endcase
    end

    // Purpose: operand latches, data-out register and address register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            opa_q  <= '0;
            opb_q  <= '0;
            dout_q <= '0;
            ar_q   <= '0;
        end else begin
            if (a_ld)    opa_q  <= rd_a;
            if (b_ld)    opb_q  <= rd_b;
            if (dout_ld) dout_q <= rd_a;
            if (ar_ld)   ar_q   <= rd_a[AW-1:0];
        end
    end

    // Purpose: drive outputs and status flags
    assign dout  = dout_q;
    assign addr  = addr_sel ? ar_q : pc_q;
    assign zero  = (rd_a == '0);
    assign nzero = |rd_a;

endmodule

// File: rtl/cpu_datapath_chk.sv
`timescale 1ns/1ps
// Module cpu_datapath_chk
// Property checker for cpu_datapath. It is attached to the top through
// the bind statement at the end of this file.
// Assumes: default widths of the top (16-bit data, 15-bit PC).
module cpu_datapath_chk #(
    parameter int DW = 16,
    parameter int AW = 15
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pc_ld,
    input  logic [1:0]    pc_src,
    input  logic          dout_ld,
    input  logic          addr_sel,
    input  logic          zero,
    input  logic          nzero,
    input  logic [DW-1:0] dout,
    input  logic [AW-1:0] addr,
    input  logic [AW-1:0] pc_q
);

    AST_RESET_DOUT: assert property (@(posedge clk)
        !rst_n |=> (dout == '0)); // R1

    AST_RESET_PC: assert property (@(posedge clk)
        !rst_n |=> (pc_q == AW'(15'h7FFE))); // R1

    AST_PC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!pc_ld || pc_src == 2'b11) |=> $stable(pc_q)); // R5

    AST_PC_INC: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_ld && pc_src == 2'b00) |=> (pc_q == AW'($past(pc_q) + AW'(1)))); // R5

    AST_ADDR_PC: assert property (@(posedge clk) disable iff (!rst_n)
        !addr_sel |-> (addr == pc_q)); // R6

    AST_DOUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !dout_ld |=> $stable(dout)); // R7

    AST_FLAG_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({zero, nzero}) == 1); // R10

endmodule

bind cpu_datapath cpu_datapath_chk #(.DW(DW), .AW(AW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .pc_ld    (pc_ld),
    .pc_src   (pc_src),
    .dout_ld  (dout_ld),
    .addr_sel (addr_sel),
    .zero     (zero),
    .nzero    (nzero),
    .dout     (dout),
    .addr     (addr),
    .pc_q     (pc_q)
);

// File: tb/cpu_datapath_bench.sv
`timescale 1ns/1ps
// Bench for cpu_datapath: sweeps registers and operations, with expected
// values computed arithmetically.
module cpu_datapath_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  sel_a = '0, sel_b = '0;
    logic [1:0]  wsrc = '0, pc_src = '0;
    logic [3:0]  op = '0;
    logic        we = 0, pc_ld = 0, dout_ld = 0, ar_ld = 0, a_ld = 0, b_ld = 0, addr_sel = 0;
    logic [15:0] din = '0;
    logic        zero, nzero;
    logic [15:0] dout;
    logic [14:0] addr;

    int errors = 0;
    int checks = 0;

    cpu_datapath u_cpu_datapath (
        .clk(clk), .rst_n(rst_n), .sel_a(sel_a), .sel_b(sel_b), .wsrc(wsrc),
        .op(op), .we(we), .pc_src(pc_src), .pc_ld(pc_ld), .dout_ld(dout_ld),
        .ar_ld(ar_ld), .a_ld(a_ld), .b_ld(b_ld), .addr_sel(addr_sel),
        .din(din), .zero(zero), .nzero(nzero), .dout(dout), .addr(addr)
    );

    always #5 clk = ~clk;

    function automatic logic [15:0] fill_val(int i);
        if (i == 31) return 16'h0000;
        return 16'(i * 16'h0913) ^ 16'h5A3C;
    endfunction

    function automatic logic [15:0] ref_alu(logic [3:0] code, logic [15:0] a, logic [15:0] b);
        case (code)
            4'h0: return a + 16'd1;
            4'h1: return a - 16'd1;
            4'h3: return b;
            4'h7: return a + b;
            4'h8: return a - b;
            4'hA: return a & b;
            4'hB: return a | b;
            4'hC: return a ^ b;
            4'hD: return ~a;
            4'hE: return 16'(a * 2);
            4'hF: return a / 2;
            default: return a;
        endcase
    endfunction

    task automatic check(string req, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle();
        we = 0; pc_ld = 0; dout_ld = 0; ar_ld = 0; a_ld = 0; b_ld = 0;
        wsrc = 2'b00; pc_src = 2'b00; op = 4'h0;
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic wr_din(int idx, logic [15:0] v);
        idle(); sel_a = 5'(idx); din = v; wsrc = 2'b00; we = 1;
        tick(); idle();
    endtask

    task automatic read_reg(int idx);
        idle(); sel_a = 5'(idx); dout_ld = 1;
        tick(); idle();
    endtask

    initial begin
        #1_000_000;
        errors++; checks++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [15:0] pairs_a [6];
        logic [15:0] pairs_b [6];
        logic [14:0] pc_old;
        pairs_a = '{16'h0F0F, 16'hFFFF, 16'h8000, 16'h0000, 16'h7FFF, 16'h1234};
        pairs_b = '{16'h00F3, 16'h0001, 16'h8000, 16'h0000, 16'hFFFF, 16'hABCD};

        // R1: reset state
        idle();
        tick(); tick(); tick();
        rst_n = 1;
        #1;
        check("R1 dout", dout, 16'h0000);
        check("R1 addr", {1'b0, addr}, 16'h7FFE);
        for (int i = 0; i < 32; i++) begin
            sel_a = 5'(i); #1;
            check("R1 cleared entry zero flag", {15'b0, zero}, 16'h0001);
        end

        // R2, R7, R10: fill every entry, read each back
        for (int i = 0; i < 32; i++) wr_din(i, fill_val(i));
        for (int i = 0; i < 32; i++) begin
            read_reg(i);
            check("R2/R7 readback", dout, fill_val(i));
            check("R10 zero", {15'b0, zero}, {15'b0, fill_val(i) == 16'h0});
            check("R10 nzero", {15'b0, nzero}, {15'b0, fill_val(i) != 16'h0});
        end

        // R4: write enable low leaves entry untouched
        idle(); sel_a = 5'd3; din = 16'hFFFF; wsrc = 2'b00; tick();
        read_reg(3);
        check("R4 no write", dout, fill_val(3));

        // R7: dout holds with strobe low
        idle(); sel_a = 5'd9; tick();
        check("R7 dout hold", dout, fill_val(3));

        // R11: write and load of same entry in one cycle
        idle(); sel_a = 5'd6; din = 16'h1111; we = 1; dout_ld = 1; tick(); idle();
        check("R11 load sees old value", dout, fill_val(6));
        read_reg(6);
        check("R11 next cycle sees new value", dout, 16'h1111);

        // R3: register copy through read port B
        idle(); sel_a = 5'd4; sel_b = 5'd6; wsrc = 2'b11; we = 1; tick(); idle();
        read_reg(4);
        check("R3 copy from port B", dout, 16'h1111);

        // R8, R9: operation sweep over operand pairs
        for (int p = 0; p < 6; p++) begin
            wr_din(1, pairs_a[p]);
            wr_din(2, pairs_b[p]);
            idle(); sel_a = 5'd1; sel_b = 5'd2; a_ld = 1; b_ld = 1; tick(); idle();
            for (int o = 0; o < 16; o++) begin
                idle(); sel_a = 5'd3; wsrc = 2'b10; op = 4'(o); we = 1; tick(); idle();
                read_reg(3);
                check("R9/R8 result", dout, ref_alu(4'(o), pairs_a[p], pairs_b[p]));
            end
        end

        // R5: PC from din drops bit 15, R6 address shows PC
        idle(); addr_sel = 0; din = 16'hC123; pc_src = 2'b01; pc_ld = 1; tick(); idle();
        check("R5 PC from din", {1'b0, addr}, 16'h4123);
        // R3: store PC
        idle(); sel_a = 5'd5; wsrc = 2'b01; we = 1; tick(); idle();
        read_reg(5);
        check("R3 PC stored", dout, 16'h4123);
        // R5: increment
        idle(); pc_src = 2'b00; pc_ld = 1; tick(); idle();
        check("R5 increment", {1'b0, addr}, 16'h4124);
        // R5: hold with load low and with source 11
        idle(); pc_src = 2'b01; din = 16'h0555; tick();
        check("R5 hold load low", {1'b0, addr}, 16'h4124);
        idle(); pc_src = 2'b11; pc_ld = 1; tick(); idle();
        check("R5 hold source 11", {1'b0, addr}, 16'h4124);
        // R5: wrap
        idle(); din = 16'h7FFF; pc_src = 2'b01; pc_ld = 1; tick(); idle();
        pc_src = 2'b00; pc_ld = 1; tick(); idle();
        check("R5 wrap", {1'b0, addr}, 16'h0000);
        // R5: from register
        idle(); sel_a = 5'd7; pc_src = 2'b10; pc_ld = 1; tick(); idle();
        check("R5 from register", {1'b0, addr}, {1'b0, fill_val(7)[14:0]});

        // R11: PC stored while incrementing keeps the old value
        pc_old = addr;
        idle(); sel_a = 5'd8; wsrc = 2'b01; we = 1; pc_src = 2'b00; pc_ld = 1; tick(); idle();
        check("R11 PC after increment", {1'b0, addr}, {1'b0, 15'(pc_old + 15'd1)});
        read_reg(8);
        check("R11 stored old PC", dout, {1'b0, pc_old});

        // R6, R7: address register
        idle(); sel_a = 5'd0; ar_ld = 1; tick(); idle();
        addr_sel = 1; #1;
        check("R6/R7 address register", {1'b0, addr}, {1'b0, fill_val(0)[14:0]});
        idle(); sel_a = 5'd11; tick();
        check("R7 address register hold", {1'b0, addr}, {1'b0, fill_val(0)[14:0]});
        addr_sel = 0; #1;
        check("R6 back to PC", {1'b0, addr}, {1'b0, 15'(pc_old + 15'd1)});

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule